// File: doc/BRIEF.md
# Front Panel Button and LED Controller

This block sits between the two front-panel pushbuttons, the front-panel LEDs and the rest of the system's platform logic. It reads the raw power and reset buttons, then synchronizes and debounces them against a millisecond tick. It measures how long the power button stays down and turns each press into one system action:

- a short press raises a power-management event when the button is released;
- a press held up to the long-press threshold forces a hard power off at once, while the button is still down;
- any press of the reset button asks for a hard reset.

The same block drives three LEDs:

- a power LED that shows the powered-on state;
- a drive LED that shows SATA activity, stretched so that short bursts stay visible;
- a beep LED that copies the speaker signal, so that beep patterns can be read where the speaker cannot be heard.

All outputs are registered. The action outputs are single-cycle pulses for the power sequencer and the reset logic.

Top module: `fp_panel_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all outputs (`pm_event`, `hard_off`, `hard_reset`, `led_pwr`, `led_hdd`, `led_beep`) are 0.
- R2: A button input counts as changed only after it has held its new level for `DEB_MS` consecutive `ms_tick` pulses. A pulse on a raw button shorter than that causes no action.
- R3: A debounced power press released before `LONG_MS` ticks of hold gives exactly one `pm_event` pulse, on release, and no `hard_off`.
- R4: A power press held for `LONG_MS` ticks gives one `hard_off` pulse while the button is still down. Releasing the button afterwards gives no `pm_event`.
- R5: Each debounced reset press, of any length, gives exactly one `hard_reset` pulse.
- R6: `led_pwr` equals the value `sys_on` had in the previous cycle.
- R7: `led_hdd` is 1 in the cycle after any cycle with `sata_act` high. It stays 1 until `STRETCH_MS` ticks have passed with no activity, then goes to 0.
- R8: `led_beep` equals the value `spkr` had in the previous cycle.
- R9: `pm_event`, `hard_off` and `hard_reset` are each high for one cycle at a time. `pm_event` and `hard_off` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pwr_btn | input | 1 | Raw power button, 1 = pressed, asynchronous |
| rst_btn | input | 1 | Raw reset button, 1 = pressed, asynchronous |
| sys_on | input | 1 | System is in the powered-on state |
| sata_act | input | 1 | SATA drive activity indication |
| spkr | input | 1 | Speaker drive signal |
| pm_event | output | 1 | Power-management event pulse (short press) |
| hard_off | output | 1 | Forced power-off pulse (long press) |
| hard_reset | output | 1 | Hard reset request pulse |
| led_pwr | output | 1 | Power LED |
| led_hdd | output | 1 | Drive activity LED |
| led_beep | output | 1 | Beep LED |

## Verification
The bench runs random power press lengths on both sides of the long-press threshold. It keeps a margin from the threshold so that the expected class does not depend on tick phase.

- A press timer with an off-by-one or a wrong comparison would put a press in the wrong class.
- A timer that failed to latch after the long press would add a `pm_event` on release.

Glitches shorter than the debounce window are driven on both buttons; a debouncer that passed them would produce actions where none are expected. Reset presses both much shorter and much longer than the threshold are checked to give a single pulse each. The drive LED is checked just before and just after its stretch window; a stretch counter that is not reloaded or never expires would show in one of those two samples.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_HELD  = 2'd1,
    PS_LATCH = 2'd2
  } press_st_e;
endpackage

// File: rtl/fp_debounce.sv
module fp_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_MS      = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEB_MS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_MS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end

  wire s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt_q <= '0;
    end else if (s == level) begin
      cnt_q <= '0;
    end else if (ms_tick) begin
      if (cnt_q == LAST) begin
        level <= s;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp_press_timer.sv
module fp_press_timer
  import fp_pkg::*;
#(
  parameter int LONG_MS = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic btn,
  output logic short_evt,
  output logic long_evt
);
  localparam int TW = $clog2(LONG_MS + 1);
  localparam logic [TW-1:0] LAST = TW'(LONG_MS - 1);

  press_st_e st_q;
  logic [TW-1:0] held_q;
  logic btn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= PS_IDLE;
      held_q    <= '0;
      btn_q     <= 1'b0;
      short_evt <= 1'b0;
      long_evt  <= 1'b0;
    end else begin
      btn_q     <= btn;
      short_evt <= 1'b0;
      long_evt  <= 1'b0;
      unique case (st_q)
        PS_IDLE: begin
          held_q <= '0;
          if (btn && !btn_q) st_q <= PS_HELD;
        end
        PS_HELD: begin
          if (!btn) begin
            short_evt <= 1'b1;
            st_q      <= PS_IDLE;
          end else if (ms_tick) begin
            if (held_q == LAST) begin
              long_evt <= 1'b1;
              st_q     <= PS_LATCH;
            end else begin
              held_q <= held_q + 1'b1;
            end
          end
        end
        PS_LATCH: if (!btn) st_q <= PS_IDLE;
        default: st_q <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fp_act_stretch.sv
module fp_act_stretch #(
  parameter int STRETCH_MS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic act,
  output logic led
);
  localparam int SW = $clog2(STRETCH_MS + 1);
  localparam logic [SW-1:0] LOAD = SW'(STRETCH_MS);

  logic [SW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      led    <= 1'b0;
    end else begin
      if (act)                        left_q <= LOAD;
      else if (ms_tick && left_q != 0) left_q <= left_q - 1'b1;
      led <= act || (left_q != 0 && !(ms_tick && left_q == 1));
    end
  end
endmodule

// File: rtl/fp_panel_ctrl.sv
module fp_panel_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_MS      = 16,
  parameter int LONG_MS     = 4000,
  parameter int STRETCH_MS  = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic pwr_btn,
  input  logic rst_btn,
  input  logic sys_on,
  input  logic sata_act,
  input  logic spkr,
  output logic pm_event,
  output logic hard_off,
  output logic hard_reset,
  output logic led_pwr,
  output logic led_hdd,
  output logic led_beep
);
  logic [1:0] raw_v, deb_v;
  assign raw_v = {rst_btn, pwr_btn};

  for (genvar i = 0; i < 2; i++) begin : g_btn
    fp_debounce #(.SYNC_STAGES(SYNC_STAGES), .DEB_MS(DEB_MS)) u_deb (
      .clk(clk), .rst(rst), .ms_tick(ms_tick), .raw(raw_v[i]), .level(deb_v[i])
    );
  end

  fp_press_timer #(.LONG_MS(LONG_MS)) u_ptim (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .btn(deb_v[0]),
    .short_evt(pm_event), .long_evt(hard_off)
  );

  logic rbtn_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rbtn_q     <= 1'b0;
      hard_reset <= 1'b0;
      led_pwr    <= 1'b0;
      led_beep   <= 1'b0;
    end else begin
      rbtn_q     <= deb_v[1];
      hard_reset <= deb_v[1] && !rbtn_q;
      led_pwr    <= sys_on;
      led_beep   <= spkr;
    end
  end

  fp_act_stretch #(.STRETCH_MS(STRETCH_MS)) u_hdd (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .act(sata_act), .led(led_hdd)
  );
endmodule

// File: rtl/fp_panel_chk.sv
module fp_panel_chk (
  input logic clk,
  input logic rst,
  input logic sys_on,
  input logic sata_act,
  input logic spkr,
  input logic pm_event,
  input logic hard_off,
  input logic hard_reset,
  input logic led_pwr,
  input logic led_hdd,
  input logic led_beep
);
  // R9
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pm_event && hard_off));
  // R9
  pm_single_chk: assert property (@(posedge clk) disable iff (rst)
    pm_event |=> !pm_event);
  // R9
  off_single_chk: assert property (@(posedge clk) disable iff (rst)
    hard_off |=> !hard_off);
  // R5
  rst_single_chk: assert property (@(posedge clk) disable iff (rst)
    hard_reset |=> !hard_reset);
  // R6
  pwr_led_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (led_pwr == $past(sys_on)));
  // R8
  beep_led_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (led_beep == $past(spkr)));
  // R7
  hdd_on_chk: assert property (@(posedge clk) disable iff (rst)
    sata_act |=> led_hdd);
endmodule

bind fp_panel_ctrl fp_panel_chk u_chk (
  .clk(clk), .rst(rst), .sys_on(sys_on), .sata_act(sata_act), .spkr(spkr),
  .pm_event(pm_event), .hard_off(hard_off), .hard_reset(hard_reset),
  .led_pwr(led_pwr), .led_hdd(led_hdd), .led_beep(led_beep)
);

// File: tb/sim_fp_panel_ctrl.sv
`timescale 1ns/1ps
module sim_fp_panel_ctrl;
  localparam int DEB  = 3;
  localparam int LONG = 20;
  localparam int STR  = 5;
  localparam int TDIV = 4;

  logic clk = 0, rst = 1, ms_tick = 0;
  logic pwr_btn = 0, rst_btn = 0, sys_on = 0, sata_act = 0, spkr = 0;
  logic pm_event, hard_off, hard_reset, led_pwr, led_hdd, led_beep;

  int checks = 0, errors = 0;
  int n_pm = 0, n_off = 0, n_rst = 0;
  logic p_pm = 0, p_off = 0, p_rst = 0;

  always #4 clk = ~clk;

  fp_panel_ctrl #(.SYNC_STAGES(2), .DEB_MS(DEB), .LONG_MS(LONG), .STRETCH_MS(STR)) u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pwr_btn(pwr_btn), .rst_btn(rst_btn),
    .sys_on(sys_on), .sata_act(sata_act), .spkr(spkr), .pm_event(pm_event),
    .hard_off(hard_off), .hard_reset(hard_reset), .led_pwr(led_pwr),
    .led_hdd(led_hdd), .led_beep(led_beep)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (TDIV - 1) @(posedge clk);
      #1 ms_tick = 1;
      @(posedge clk);
      #1 ms_tick = 0;
    end
  end

  // pulse counting and single-cycle check (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (pm_event) n_pm++;
      if (hard_off) n_off++;
      if (hard_reset) n_rst++;
      if ((pm_event && p_pm) || (hard_off && p_off) || (hard_reset && p_rst) ||
          (pm_event && hard_off)) begin
        checks++; errors++;
        $display("FAIL R9 actual=overlap expected=single");
      end
    end
    p_pm = pm_event; p_off = hard_off; p_rst = hard_reset;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic bit is_long(input int ticks);
    return ticks >= LONG;
  endfunction

  task automatic pwr_press(input int ticks);
    int pm0, off0;
    pm0 = n_pm; off0 = n_off;
    pwr_btn = 1;
    cyc(ticks * TDIV);
    if (is_long(ticks)) chk("R4 off while held", n_off - off0, 1);
    pwr_btn = 0;
    cyc((DEB + 4) * TDIV);
    if (is_long(ticks)) begin
      chk("R4 long no pm", n_pm - pm0, 0);
      chk("R4 long off", n_off - off0, 1);
    end else begin
      chk("R3 short pm", n_pm - pm0, 1);
      chk("R3 short no off", n_off - off0, 0);
    end
  endtask

  task automatic rst_press(input int ticks);
    int r0;
    r0 = n_rst;
    rst_btn = 1;
    cyc(ticks * TDIV);
    rst_btn = 0;
    cyc((DEB + 4) * TDIV);
    chk("R5 reset pulse", n_rst - r0, 1);
  endtask

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    cyc(5);
    @(negedge clk);
    chk("R1 pm", pm_event, 0); chk("R1 off", hard_off, 0); chk("R1 rst", hard_reset, 0);
    chk("R1 leds", {led_pwr, led_hdd, led_beep}, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R1 after", {pm_event, hard_off, hard_reset, led_pwr, led_hdd, led_beep}, 0);
    cyc(4 * TDIV);

    // R2 glitches
    begin
      int a, b, c;
      a = n_pm; b = n_off; c = n_rst;
      for (int i = 0; i < 4; i++) begin
        pwr_btn = 1; cyc(TDIV); pwr_btn = 0; cyc(2 * TDIV);
        rst_btn = 1; cyc(TDIV); rst_btn = 0; cyc(2 * TDIV);
      end
      cyc((DEB + 4) * TDIV);
      chk("R2 glitch pwr", (n_pm - a) + (n_off - b), 0);
      chk("R2 glitch rst", n_rst - c, 0);
    end

    // directed edges of the press classes
    pwr_press(DEB + 2);
    pwr_press(LONG - 3);
    pwr_press(LONG + DEB + 3);
    // random press lengths, away from the threshold
    for (int i = 0; i < 14; i++) begin
      if ($urandom % 2) pwr_press(DEB + 2 + ($urandom % (LONG - DEB - 4)));
      else              pwr_press(LONG + DEB + 3 + ($urandom % 12));
    end
    rst_press(DEB + 1);
    rst_press(LONG * 3);
    for (int i = 0; i < 3; i++) rst_press(DEB + 1 + ($urandom % 30));

    // R6, R8 random following
    for (int i = 0; i < 40; i++) begin
      logic so, sp;
      so = 1'($urandom); sp = 1'($urandom);
      sys_on = so; spkr = sp;
      @(posedge clk); @(negedge clk);
      chk("R6 led_pwr", led_pwr, so);
      chk("R8 led_beep", led_beep, sp);
      @(posedge clk); #1;
    end

    // R7 stretch
    for (int k = 0; k < 3; k++) begin
      cyc((STR + 3) * TDIV);
      sata_act = 1; cyc(1 + k); sata_act = 0;
      @(negedge clk);
      chk("R7 hdd on", led_hdd, 1);
      cyc((STR - 2) * TDIV);
      @(negedge clk);
      chk("R7 hdd held", led_hdd, 1);
      cyc(4 * TDIV);
      @(negedge clk);
      chk("R7 hdd off", led_hdd, 0);
      @(posedge clk); #1;
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule